// File: doc/BRIEF.md
# I2C command tag sequence generator

This block takes one I2C message request and produces the command-tag bytes that a tag-driven I2C master consumes. A request carries a 7- or 10-bit target address, a read/write flag, a flag that selects ten-bit addressing, and a byte length from 1 to 65535. The generator cuts the message into blocks of at most 256 bytes. For each block it sends the tag bytes one at a time on a byte-wide valid/ready stream. The index and byte count of the block travel alongside each byte.

Only the first block opens with the START tag and the address. Only the final block uses the opcode that ends with a stop condition. No STOP is issued between blocks. After a block that is not the last, the generator raises a done pulse and waits for an acknowledge before it sends the next block. The payload bytes and the bus-level signalling are handled by the blocks downstream.

Top module: `i2c_tag_seq`

## Requirements
- R1: After reset the block is idle: busy, tag_valid, err_pulse and block_done are low and req_ready is high.
- R2: A request accepted with req_len equal to 0 gives a one-cycle err_pulse in the cycle after acceptance. No tag byte is emitted and busy stays low.
- R3: The first block starts with the byte 0x81. Next comes the byte ((addr << 1) | read)[7:0]. When req_ten is set, a further byte ((addr << 1) | read) >> 8 follows.
- R4: Each block has one opcode byte: 0x82 for a write and 0x85 for a read. The last block of a message uses 0x83 for a write and 0x87 for a read instead.
- R5: A message has ceil(len/256) blocks. Each block carries min(remaining, 256) bytes and is numbered from 0. The opcode is followed by a length byte equal to that count modulo 256, so 0 stands for 256. While tag_valid is high, tag_blk_idx and tag_blk_cnt show the index and count of the current block.
- R6: Every block after the first consists of exactly two tag bytes: the opcode and then the length.
- R7: While tag_valid is high and tag_ready is low, tag_valid stays high and tag_byte, tag_blk_idx and tag_blk_cnt keep their values.
- R8: block_done is a one-cycle pulse in the cycle after the final tag byte of each block is accepted.
- R9: After a block that is not the last, tag_valid stays low until block_ack is seen high. The next block's first byte is offered in the cycle after that. block_ack has no effect while tags are being emitted or while the block is idle.
- R10: busy is high from the cycle after a non-empty request is accepted until the cycle after the last tag of the last block is accepted. req_ready is high exactly when busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 10 | Target address (7-bit in the low bits) |
| req_read | input | 1 | 1 = read message, 0 = write |
| req_ten | input | 1 | Ten-bit addressing selected |
| req_len | input | 16 | Message length in bytes |
| err_pulse | output | 1 | Zero-length request rejected |
| tag_valid | output | 1 | Tag byte offered |
| tag_ready | input | 1 | Downstream takes the tag byte |
| tag_byte | output | 8 | Tag byte |
| tag_blk_idx | output | 8 | Index of the current block |
| tag_blk_cnt | output | 9 | Byte count of the current block (1..256) |
| block_done | output | 1 | Final tag of a block accepted |
| block_ack | input | 1 | Permission to start the next block |
| busy | output | 1 | Message in progress |

## Verification
The tag stream is combinational from state, so a tag byte is checked at the falling edge that precedes the rising edge where it is taken. The scoreboard pops one expected byte per handshake seen at a falling edge. block_done and err_pulse come from a single register, so the bench expects each of them at the first falling edge after the rising edge that caused it: the final tag handshake for block_done, and the acceptance of a zero-length request for err_pulse. After a non-final block the bench holds block_ack low for a set number of cycles and checks tag_valid low at each of them. It then raises block_ack and expects the next block's first byte at the falling edge after the acknowledging rising edge.

// File: rtl/i2c_tag_pkg.sv
package i2c_tag_pkg;

  localparam logic [7:0] TAG_START   = 8'h81;
  localparam logic [7:0] OP_WR       = 8'h82;
  localparam logic [7:0] OP_WR_STOP  = 8'h83;
  localparam logic [7:0] OP_RD       = 8'h85;
  localparam logic [7:0] OP_RD_STOP  = 8'h87;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EMIT = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

  // opcode for a block: stop flavour only on the final block
  function automatic logic [7:0] op_code(input logic rd, input logic last);
    if (rd) return last ? OP_RD_STOP : OP_RD;
    else    return last ? OP_WR_STOP : OP_WR;
  endfunction

  // number of tag bytes in a block
  function automatic logic [2:0] tag_total(input logic first, input logic ten);
    if (!first) return 3'd2;
    return ten ? 3'd5 : 3'd4;
  endfunction

  // tag byte at position pos within a block
  function automatic logic [7:0] tag_at(input logic [2:0] pos, input logic first,
                                        input logic ten, input logic [7:0] lo,
                                        input logic [7:0] hi, input logic [7:0] op,
                                        input logic [7:0] lenb);
    if (!first) return (pos == 3'd0) ? op : lenb;
    case (pos)
      3'd0:    return TAG_START;
      3'd1:    return lo;
      3'd2:    return ten ? hi : op;
      3'd3:    return ten ? op : lenb;
      default: return lenb;
    endcase
  endfunction

endpackage

// File: rtl/i2c_tag_blkctr.sv
module i2c_tag_blkctr #(
  parameter int LEN_W     = 16,
  parameter int BLK_BYTES = 256,
  localparam int BLK_SHIFT = $clog2(BLK_BYTES),
  localparam int IDX_W     = LEN_W - BLK_SHIFT,
  localparam int CNT_W     = BLK_SHIFT + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic             advance,
  input  logic             active,
  output logic [IDX_W-1:0] blk_idx,
  output logic [CNT_W-1:0] blk_cnt,
  output logic             last_blk
);

  logic [LEN_W-1:0] remaining;
  logic             big;

  assign big      = remaining > LEN_W'(BLK_BYTES);
  assign last_blk = !big;
  assign blk_cnt  = big ? CNT_W'(BLK_BYTES) : remaining[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
      blk_idx   <= '0;
    end else if (load) begin
      remaining <= len_in;
      blk_idx   <= '0;
    end else if (advance) begin
      remaining <= remaining - LEN_W'(blk_cnt);
      blk_idx   <= blk_idx + IDX_W'(1);
    end
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (blk_cnt != '0) && (blk_cnt <= CNT_W'(BLK_BYTES)));

endmodule

// File: rtl/i2c_tag_builder.sv
module i2c_tag_builder #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              ten,
  input  logic              first,
  input  logic              last,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [2:0]        pos,
  output logic [7:0]        tag,
  output logic [2:0]        ntags
);
  import i2c_tag_pkg::*;

  logic [ADDR_W:0] aword;
  logic [7:0]      lo, hi, op, lenb;

  assign aword = {addr, rd};
  assign lo    = aword[7:0];
  assign hi    = 8'(aword >> 8);
  assign op    = op_code(rd, last);
  assign lenb  = 8'(cnt);       // 256 wraps to 0
  assign ntags = tag_total(first, ten);
  assign tag   = tag_at(pos, first, ten, lo, hi, op, lenb);

endmodule

// File: rtl/i2c_tag_seq.sv
module i2c_tag_seq #(
  parameter int ADDR_W    = 10,
  parameter int LEN_W     = 16,
  parameter int BLK_BYTES = 256,
  localparam int BLK_SHIFT = $clog2(BLK_BYTES),
  localparam int IDX_W     = LEN_W - BLK_SHIFT,
  localparam int CNT_W     = BLK_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_read,
  input  logic              req_ten,
  input  logic [LEN_W-1:0]  req_len,
  output logic              err_pulse,
  output logic              tag_valid,
  input  logic              tag_ready,
  output logic [7:0]        tag_byte,
  output logic [IDX_W-1:0]  tag_blk_idx,
  output logic [CNT_W-1:0]  tag_blk_cnt,
  output logic              block_done,
  input  logic              block_ack,
  output logic              busy
);
  import i2c_tag_pkg::*;

  seq_state_e        state;
  logic [2:0]        pos;
  logic [2:0]        ntags;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q, ten_q;
  logic              last_blk;
  logic              err_q, done_q;

  // named internal events
  logic accept, zero_req, start_msg, fire, end_of_blk, first_blk;

  assign req_ready  = (state == ST_IDLE);
  assign busy       = (state != ST_IDLE);
  assign tag_valid  = (state == ST_EMIT);
  assign accept     = req_valid && req_ready;
  assign zero_req   = accept && (req_len == '0);
  assign start_msg  = accept && (req_len != '0);
  assign fire       = tag_valid && tag_ready;
  assign end_of_blk = fire && (pos == ntags - 3'd1);
  assign first_blk  = (tag_blk_idx == '0);
  assign err_pulse  = err_q;
  assign block_done = done_q;

  i2c_tag_blkctr #(.LEN_W(LEN_W), .BLK_BYTES(BLK_BYTES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(start_msg), .len_in(req_len),
    .advance(end_of_blk), .active(tag_valid), .blk_idx(tag_blk_idx),
    .blk_cnt(tag_blk_cnt), .last_blk(last_blk)
  );

  i2c_tag_builder #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_bld (
    .addr(addr_q), .rd(rd_q), .ten(ten_q), .first(first_blk), .last(last_blk),
    .cnt(tag_blk_cnt), .pos(pos), .tag(tag_byte), .ntags(ntags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pos    <= '0;
      addr_q <= '0;
      rd_q   <= 1'b0;
      ten_q  <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      err_q  <= zero_req;
      done_q <= end_of_blk;
      case (state)
        ST_IDLE: if (start_msg) begin
          state  <= ST_EMIT;
          pos    <= '0;
          addr_q <= req_addr;
          rd_q   <= req_read;
          ten_q  <= req_ten;
        end
        ST_EMIT: if (end_of_blk) begin
          pos   <= '0;
          state <= last_blk ? ST_IDLE : ST_WAIT;
        end else if (fire) begin
          pos <= pos + 3'd1;
        end
        ST_WAIT: if (block_ack) state <= ST_EMIT;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid && !tag_ready |=> tag_valid && $stable(tag_byte) &&
      $stable(tag_blk_idx) && $stable(tag_blk_cnt));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |=> !block_done);

  // R2
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !busy && !tag_valid && !block_done);

  // R10
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid) && $past(req_len != '0));

  // R9
  wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) && !block_ack |=> !tag_valid);

endmodule

// File: tb/i2c_tag_seq_tb.sv
module i2c_tag_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [9:0] req_addr = '0;
  logic       req_read = 1'b0;
  logic       req_ten = 1'b0;
  logic [15:0] req_len = '0;
  logic       err_pulse;
  logic       tag_valid;
  logic       tag_ready = 1'b0;
  logic [7:0] tag_byte;
  logic [7:0] tag_blk_idx;
  logic [8:0] tag_blk_cnt;
  logic       block_done;
  logic       block_ack = 1'b0;
  logic       busy;

  always #10 clk = ~clk;

  i2c_tag_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_read(req_read), .req_ten(req_ten), .req_len(req_len),
    .err_pulse(err_pulse), .tag_valid(tag_valid), .tag_ready(tag_ready),
    .tag_byte(tag_byte), .tag_blk_idx(tag_blk_idx), .tag_blk_cnt(tag_blk_cnt),
    .block_done(block_done), .block_ack(block_ack), .busy(busy)
  );

  typedef struct packed {
    logic [7:0] b;
    logic [7:0] idx;
    logic [8:0] cnt;
    logic [1:0] kind;   // 0 start/addr, 1 opcode, 2 length
    logic       eob;
    logic       lastb;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0, n_fail = 0;
  int   ack_delay = 1;
  bit   spurious_ack = 1'b0;
  bit   full_ready = 1'b0;
  bit   done_run = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int b, input int idx, input int cnt, input int kind,
                      input bit eob, input bit lastb);
    exp_t e;
    e.b = 8'(b); e.idx = 8'(idx); e.cnt = 9'(cnt); e.kind = 2'(kind);
    e.eob = eob; e.lastb = lastb;
    sb.push_back(e);
  endtask

  // driver: build expected stream, then offer request
  task automatic send(input int addr, input bit rd, input bit ten, input int len);
    int rem, nb, word;
    word = (addr << 1) | int'(rd);
    rem = len;
    nb = (len + 255) / 256;
    for (int b = 0; b < nb; b++) begin
      int cnt, op;
      bit last;
      cnt  = (rem > 256) ? 256 : rem;
      last = (b == nb - 1);
      if (rd) op = last ? 'h87 : 'h85;
      else    op = last ? 'h83 : 'h82;
      if (b == 0) begin
        push('h81, b, cnt, 0, 0, last);
        push(word & 'hff, b, cnt, 0, 0, last);
        if (ten) push(word >> 8, b, cnt, 0, 0, last);
      end
      push(op, b, cnt, 1, 0, last);
      push(cnt % 256, b, cnt, 2, 1, last);
      rem -= cnt;
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr = 10'(addr); req_read = rd; req_ten = ten; req_len = 16'(len);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (len == 0) begin
      chk(err_pulse == 1'b1, "R2 err_pulse", int'(err_pulse), 1);
      chk(busy == 1'b0, "R2 busy", int'(busy), 0);
      @(negedge clk);
      chk(err_pulse == 1'b0, "R2 err one cycle", int'(err_pulse), 0);
      chk(tag_valid == 1'b0, "R2 no tags", int'(tag_valid), 0);
    end else begin
      chk(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
      chk(req_ready == 1'b0, "R10 ready low", int'(req_ready), 0);
      while (sb.size() != 0 || busy) @(negedge clk);
    end
  endtask

  // tag_ready pattern
  initial begin
    logic [7:0] lfsr = 8'h5a;
    forever begin
      @(posedge clk);
      #2;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tag_ready = full_ready ? 1'b1 : (lfsr[0] | lfsr[2]);
    end
  end

  // monitor / scoreboard
  initial begin
    bit exp_done = 0, exp_lastb = 0, stall = 0;
    int wait_cnt = 0;
    logic [7:0] hold_b = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (exp_done) begin
          chk(block_done == 1'b1, "R8 block_done", int'(block_done), 1);
          if (exp_lastb) begin
            chk(busy == 1'b0 && req_ready == 1'b1, "R10 idle after last", int'(busy), 0);
          end else begin
            chk(busy == 1'b1, "R10 busy between blocks", int'(busy), 1);
            wait_cnt = ack_delay;
          end
        end else if (block_done) begin
          chk(1'b0, "R8 unexpected block_done", 1, 0);
        end
        exp_done = 0;
        if (stall && tag_valid)
          chk(tag_byte == hold_b, "R7 hold", int'(tag_byte), int'(hold_b));
        else if (stall)
          chk(1'b0, "R7 valid dropped", 0, 1);
        if (wait_cnt > 0) begin
          chk(tag_valid == 1'b0, "R9 wait for ack", int'(tag_valid), 0);
          wait_cnt--;
          block_ack = (wait_cnt == 0);
        end else begin
          block_ack = spurious_ack && tag_valid;
        end
        stall = tag_valid && !tag_ready;
        hold_b = tag_byte;
        if (tag_valid && tag_ready) begin
          if (sb.size() == 0) begin
            chk(1'b0, "R2 unexpected tag", int'(tag_byte), 0);
          end else begin
            exp_t e;
            string lbl;
            e = sb.pop_front();
            if (e.idx != 0)        lbl = "R6 later block";
            else if (e.kind == 0)  lbl = "R3 start/addr";
            else if (e.kind == 1)  lbl = "R4 opcode";
            else                   lbl = "R5 length";
            chk(tag_byte == e.b, lbl, int'(tag_byte), int'(e.b));
            chk(tag_blk_idx == e.idx && tag_blk_cnt == e.cnt, "R5 block idx/cnt",
                int'({tag_blk_idx, tag_blk_cnt}), int'({e.idx, e.cnt}));
            if (e.eob) begin
              exp_done = 1;
              exp_lastb = e.lastb;
            end
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done_run) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && tag_valid == 0, "R1 reset idle", int'({busy, tag_valid}), 0);
    chk(req_ready == 1 && err_pulse == 0 && block_done == 0, "R1 reset outputs",
        int'({req_ready, err_pulse, block_done}), 4);
    // R3 R4: short 7-bit write
    send('h50, 0, 0, 1);
    // R5: exactly one full block, length byte 0
    full_ready = 1'b1;
    send('h3C, 1, 0, 256);
    // R6 R8 R9: two blocks, spurious acks while emitting
    full_ready = 1'b0; spurious_ack = 1'b1; ack_delay = 3;
    send('h12, 0, 0, 257);
    // R3 ten-bit read, three blocks
    ack_delay = 1;
    send('h2A5, 1, 1, 600);
    // R2 zero length
    send('h33, 0, 0, 0);
    // ten-bit write, 512 bytes
    ack_delay = 2; spurious_ack = 1'b0;
    send('h1FF, 0, 1, 512);
    // maximum length
    full_ready = 1'b1; ack_delay = 1;
    send('h7F, 1, 0, 65535);
    repeat (3) @(negedge clk);
    chk(busy == 0 && tag_valid == 0, "R10 idle at end", int'({busy, tag_valid}), 0);
    done_run = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule